// File: doc/BRIEF.md
# Dual PWM Gain-Control Output Generator

This block turns two gain-control words into two pulse-width-modulated pins that drive gain amplifiers through external RC low-pass filters. One pin serves the tuner gain stage and the other the IF gain stage. Both pins are open-drain: each is either pulled low or released to the external pull-up. A shared timebase sets the PWM period. Each channel compares its active duty word against the running phase of that period.

A gain-control loop outside this block supplies fresh words at any time. The block samples them only after every 512th sample strobe, which limits how often the gain can change. A sampled word waits in a pending register and becomes active at the next period boundary, so no period is ever cut short or stretched. The IF channel can leave the loop and load a fixed duty from a programmed register value instead. The tuner channel always follows the loop.

Top module: `dual_pwm_gain_out`

## Requirements
- R1: While reset is asserted and after it is released, both channels hold a pending and an active duty of mid-scale (2^(DUTY_W-1)). The first period after reset therefore runs at mid-scale duty on both pins.
- R2: The PWM period is PRE_DIV * 2^DUTY_W clock cycles. The phase advances by one every PRE_DIV cycles and runs from 0 to 2^DUTY_W-1 before it wraps. This count must be at least 16, which caps the pulse rate at one sixteenth of the clock.
- R3: The gain words are sampled into the pending registers only in a cycle whose strobe completes a group of 512 strobes, that is, when the 9-bit strobe count wraps from 511 to 0. A change on the gain inputs at any other time has no effect.
- R4: A pending word becomes the active duty only at a period boundary, which is the cycle in which the phase wraps to 0. If a capture and a boundary fall in the same cycle, the new word takes effect at the following boundary.
- R5: An active duty of 0 keeps the pin pulled low (pull output = 1) for the whole period.
- R6: An active duty of all ones keeps the pin released (pull output = 0) for the whole period.
- R7: For any other active duty D, the pin is released while the phase is below D and pulled low for the rest of the period. A pull output of 1 means the pin is driven low.
- R8: When the fixed-duty select is 1 at a period boundary, the IF channel loads the programmed fixed duty instead of its pending word. The select is examined only at boundaries, and the tuner channel never uses it.
- R9: The strobe count advances only in cycles with the strobe high. Cycles without a strobe neither advance nor clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the timebase and all registers |
| rst_n | input | 1 | Asynchronous reset, active low |
| samp_stb | input | 1 | One pulse per converter sample |
| gain_tuner | input | DUTY_W | Loop gain word for the tuner channel |
| gain_if | input | DUTY_W | Loop gain word for the IF channel |
| if_fixed_sel | input | 1 | 1 selects the fixed duty for the IF channel |
| if_fixed_duty | input | DUTY_W | Programmed fixed duty for the IF channel |
| tuner_pull_low | output | 1 | 1 drives the tuner pin low, 0 releases it |
| if_pull_low | output | 1 | 1 drives the IF pin low, 0 releases it |

## Verification
The hardest case to reach is a gain capture that falls in the same cycle as a period boundary. The 512-strobe rhythm and the PWM period line up only for certain strobe patterns. The stimulus first sends a strobe every cycle. Because 512 is a multiple of the bench period, every capture then lands at the same phase. It then switches to sparse and irregular strobe spacing, which slides the capture point across the period until it meets the boundary. A cycle-accurate model in the bench tracks both buffers, and its output is compared with both pins on every clock. The stimulus also changes the loop words and the select between boundaries to show that those changes are ignored.

// File: rtl/gain_pwm_pkg.sv
package gain_pwm_pkg;
    typedef enum int {
        CH_TUNER = 0,
        CH_IF    = 1
    } gain_ch_e;

    localparam int NUM_CH = 2;
endpackage

// File: rtl/sample_group_tick.sv
module sample_group_tick #(
    parameter int SAMP_W = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    output logic tick
);
    typedef struct packed {
        logic [SAMP_W-1:0] cnt;
    } grp_state_t;

    grp_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        tick = stb && (st_q.cnt == '1);
        if (stb) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> $stable(st_q.cnt));
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
    parameter int DUTY_W  = 8,
    parameter int PRE_DIV = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              wrap,
    output logic [DUTY_W-1:0] phase_nxt
);
    localparam int PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [DUTY_W-1:0] phase;
    } tb_state_t;

    tb_state_t st_q, st_d;
    logic      step;

    always_comb begin
        st_d = st_q;
        step = (st_q.pre == PRE_LAST);
        wrap = step && (st_q.phase == '1);
        if (step) begin
            st_d.pre   = '0;
            st_d.phase = st_q.phase + 1'b1;
        end else begin
            st_d.pre   = st_q.pre + 1'b1;
        end
        phase_nxt = st_d.phase;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(st_q.phase));
endmodule

// File: rtl/pwm_gain_channel.sv
module pwm_gain_channel #(
    parameter int DUTY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [DUTY_W-1:0] cap_val,
    input  logic              wrap,
    input  logic              use_fixed,
    input  logic [DUTY_W-1:0] fixed_duty,
    input  logic [DUTY_W-1:0] phase_nxt,
    output logic              pull_low
);
    localparam logic [DUTY_W-1:0] MID = DUTY_W'(1) << (DUTY_W - 1);

    typedef struct packed {
        logic [DUTY_W-1:0] pend;
        logic [DUTY_W-1:0] act;
        logic              pull;
    } ch_state_t;

    ch_state_t st_q, st_d;
    logic [DUTY_W-1:0] phase_q;

    always_comb begin
        st_d = st_q;
        if (wrap) st_d.act = use_fixed ? fixed_duty : st_q.pend;
        if (cap)  st_d.pend = cap_val;
        st_d.pull = !((st_d.act == '1) || (phase_nxt < st_d.act));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend <= MID;
            st_q.act  <= MID;
            st_q.pull <= 1'b0;
            phase_q   <= '0;
        end else begin
            st_q    <= st_d;
            phase_q <= phase_nxt;
        end
    end

    assign pull_low = st_q.pull;

    // R4
    act_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(st_q.act));
    // R3
    pend_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(st_q.pend));
    // R5
    zero_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act == '0) |-> pull_low);
    // R6
    full_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act == '1) |-> !pull_low);
    // R7
    edge_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q >= st_q.act) && (st_q.act != '1) |-> pull_low);
endmodule

// File: rtl/dual_pwm_gain_out.sv
module dual_pwm_gain_out #(
    parameter int DUTY_W  = 8,
    parameter int PRE_DIV = 1,
    parameter int SAMP_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_stb,
    input  logic [DUTY_W-1:0] gain_tuner,
    input  logic [DUTY_W-1:0] gain_if,
    input  logic              if_fixed_sel,
    input  logic [DUTY_W-1:0] if_fixed_duty,
    output logic              tuner_pull_low,
    output logic              if_pull_low
);
    import gain_pwm_pkg::*;

    logic              tick;
    logic              wrap;
    logic [DUTY_W-1:0] phase_nxt;
    logic [DUTY_W-1:0] ch_gain  [NUM_CH];
    logic              ch_fixed [NUM_CH];
    logic              ch_pull  [NUM_CH];

    sample_group_tick #(.SAMP_W(SAMP_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .stb(samp_stb), .tick(tick)
    );

    pwm_timebase #(.DUTY_W(DUTY_W), .PRE_DIV(PRE_DIV)) u_tb (
        .clk(clk), .rst_n(rst_n), .wrap(wrap), .phase_nxt(phase_nxt)
    );

    always_comb begin
        ch_gain[CH_TUNER]  = gain_tuner;
        ch_gain[CH_IF]     = gain_if;
        ch_fixed[CH_TUNER] = 1'b0;
        ch_fixed[CH_IF]    = if_fixed_sel;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pwm_gain_channel #(.DUTY_W(DUTY_W)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .cap(tick), .cap_val(ch_gain[c]),
            .wrap(wrap), .use_fixed(ch_fixed[c]),
            .fixed_duty(if_fixed_duty), .phase_nxt(phase_nxt),
            .pull_low(ch_pull[c])
        );
    end

    assign tuner_pull_low = ch_pull[CH_TUNER];
    assign if_pull_low    = ch_pull[CH_IF];

    // R3
    tick_needs_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> samp_stb);
endmodule

// File: tb/dual_pwm_gain_out_bench.sv
module dual_pwm_gain_out_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW  = 4;
    localparam int PRE = 2;
    localparam int SW  = 9;
    localparam int DMAX  = (1 << DW) - 1;
    localparam int GROUP = 1 << SW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic samp_stb = 1'b0;
    logic [DW-1:0] gain_tuner = '0;
    logic [DW-1:0] gain_if = '0;
    logic if_fixed_sel = 1'b0;
    logic [DW-1:0] if_fixed_duty = '0;
    logic tuner_pull_low, if_pull_low;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // reference model state
    int m_cnt, m_pre, m_phase;
    int m_pend[2];
    int m_act[2];

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_pwm_gain_out #(.DUTY_W(DW), .PRE_DIV(PRE), .SAMP_W(SW)) u_dual_pwm_gain_out (
        .clk(clk), .rst_n(rst_n), .samp_stb(samp_stb),
        .gain_tuner(gain_tuner), .gain_if(gain_if),
        .if_fixed_sel(if_fixed_sel), .if_fixed_duty(if_fixed_duty),
        .tuner_pull_low(tuner_pull_low), .if_pull_low(if_pull_low)
    );

    function automatic bit exp_pull(int act, int ph);
        return !((act == DMAX) || (ph < act));
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_pre = 0; m_phase = 0;
            for (int i = 0; i < 2; i++) begin
                m_pend[i] = 1 << (DW - 1);
                m_act[i]  = 1 << (DW - 1);
            end
        end else begin
            bit tk, stp, wr;
            tk  = samp_stb && (m_cnt == GROUP - 1);
            stp = (m_pre == PRE - 1);
            wr  = stp && (m_phase == DMAX);
            if (samp_stb) m_cnt = (m_cnt + 1) % GROUP;
            if (wr) begin
                m_act[0] = m_pend[0];
                m_act[1] = if_fixed_sel ? int'(if_fixed_duty) : m_pend[1];
            end
            if (tk) begin
                m_pend[0] = gain_tuner;
                m_pend[1] = gain_if;
            end
            if (stp) begin
                m_pre = 0;
                m_phase = (m_phase + 1) % (DMAX + 1);
            end else begin
                m_pre = m_pre + 1;
            end
        end
    end

    task automatic check(string req, string what, bit got, bit expv);
        checks++;
        if (got !== expv) begin
            errors++;
            $display("FAIL %s %s got %0b expected %0b", req, what, got, expv);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            check(cur_req, "tuner_pull_low", tuner_pull_low, exp_pull(m_act[0], m_phase));
            check(cur_req, "if_pull_low", if_pull_low, exp_pull(m_act[1], m_phase));
        end
    end

    task automatic run(int n, int stb_every);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            samp_stb = (stb_every > 0) && ((i % stb_every) == 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset value, mid-scale duty at phase 0 means released
        check("R1", "tuner reset", tuner_pull_low, 1'b0);
        check("R1", "if reset", if_pull_low, 1'b0);
        rst_n = 1'b1;
        cur_req = "R1";
        run(40, 0);
        // R7 R3 R4: mid-group changes are ignored until the capture
        cur_req = "R7";
        gain_tuner = 4'd3; gain_if = 4'd10;
        run(300, 1);
        cur_req = "R3";
        gain_tuner = 4'd12; gain_if = 4'd1;
        run(400, 1);
        cur_req = "R4";
        run(500, 1);
        // R5 R6: extremes
        cur_req = "R5";
        gain_tuner = 4'd0; gain_if = 4'd15;
        run(600, 1);
        cur_req = "R6";
        gain_tuner = 4'd15; gain_if = 4'd0;
        run(600, 1);
        // R8: fixed duty on IF, select toggled between boundaries
        cur_req = "R8";
        if_fixed_duty = 4'd6; if_fixed_sel = 1'b1;
        gain_tuner = 4'd9; gain_if = 4'd2;
        run(100, 1);
        if_fixed_sel = 1'b0; run(13, 1);
        if_fixed_sel = 1'b1; run(500, 1);
        if_fixed_sel = 1'b0;
        // R9 R2: sparse and irregular strobes slide the capture point
        cur_req = "R9";
        for (int k = 0; k < 6; k++) begin
            gain_tuner = DW'(k * 5 + 1); gain_if = DW'(14 - k * 2);
            run(1100, 3 + k);
        end
        cur_req = "R2";
        run(2000, 7);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog %s got timeout expected completion", cur_req);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule